// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block forms memory addresses for a real-mode, 16-bit segmented processor. Each request names up to one base register (BX or BP), up to one index register (SI or DI) and an optional displacement. The block adds these into a 16-bit effective offset, picks a segment, and produces the 20-bit physical address as the segment shifted left by four bits plus the offset. A separate fetch request forms the instruction address from the code segment and the instruction pointer.

The default segment follows the base register in use: SS when BP takes part, DS otherwise. An explicit override input can select any of the four segments in its place. Register pairings the machine cannot encode raise an error flag instead of producing an address. A request is presented with `valid_i`, and the results appear registered on the next clock with a one-cycle `valid_o` pulse.

Top module: `seg_agu`

## Requirements
- R1: `pa_o` equals (segment × 16 + `ea_o`) modulo 2^20, so a segment near the top of the map wraps through address 0.
- R2: `ea_o` equals base + index + displacement modulo 2^16, where an absent term adds zero. `base_sel_i` encodes 00 none, 01 BX, 10 BP; `idx_sel_i` encodes 00 none, 01 SI, 10 DI.
- R3: `disp_sel_i` encodes 00 no displacement, 01 an 8-bit signed displacement taken from `disp_i[7:0]` and sign-extended to 16 bits, 10 the full 16-bit `disp_i`.
- R4: Without an override, a request using BP takes SS as its segment; every other data request, including displacement-only (direct) requests, takes DS.
- R5: With `fetch_i` high the segment is CS and the offset is `ip_i`; the base, index, displacement and override inputs have no effect and the error flag stays low.
- R6: With `ovr_en_i` high, `ovr_seg_i` replaces the default segment: 00 ES, 01 CS, 10 SS, 11 DS.
- R7: A data request with `idx_sel_i` = 11 (SI and DI together), `base_sel_i` = 11 (BX and BP together) or `disp_sel_i` = 11 sets `err_o` and drives `ea_o` and `pa_o` to zero.
- R8: Outputs update on the clock edge after a cycle with `valid_i` high, `valid_o` is high for exactly that following cycle, and the data outputs hold their values while `valid_i` is low.
- R9: During and after reset, before any request, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| fetch_i | input | 1 | Instruction fetch request (CS:IP) |
| base_sel_i | input | 2 | Base register select |
| idx_sel_i | input | 2 | Index register select |
| disp_sel_i | input | 2 | Displacement size select |
| disp_i | input | 16 | Displacement value |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment select |
| cs_i | input | 16 | Code segment value |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| es_i | input | 16 | Extra segment value |
| ip_i | input | 16 | Instruction pointer |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| valid_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective offset |
| pa_o | output | 20 | Physical address |
| err_o | output | 1 | Illegal register combination |

## Verification
The bench sweeps every combination of base, index, displacement size, override and fetch over three register sets, one of them chosen so that both the 16-bit offset sum and the 20-bit physical sum overflow. An adder that carried into bit 16 of the offset, or kept bit 20 of the address, would miss the wrap cases. A displacement zero-extended instead of sign-extended shows up with the 0x80 byte. A segment choice keyed on the index instead of the base, or an override that leaks into fetches, gives a wrong segment in the BP and fetch sweeps. The hold and pulse checks catch a register that loads on every clock.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic [1:0] {BASE_NONE = 2'd0, BASE_BX = 2'd1, BASE_BP = 2'd2, BASE_BAD = 2'd3} base_sel_e;
  typedef enum logic [1:0] {IDX_NONE = 2'd0, IDX_SI = 2'd1, IDX_DI = 2'd2, IDX_BAD = 2'd3} idx_sel_e;
  typedef enum logic [1:0] {DISP_NONE = 2'd0, DISP_S8 = 2'd1, DISP_W16 = 2'd2, DISP_BAD = 2'd3} disp_sel_e;
  typedef enum logic [1:0] {SEG_ES = 2'd0, SEG_CS = 2'd1, SEG_SS = 2'd2, SEG_DS = 2'd3} seg_sel_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset
  import seg_agu_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int DISP_S_W = 8
) (
  input  logic [1:0]       base_sel_i,
  input  logic [1:0]       idx_sel_i,
  input  logic [1:0]       disp_sel_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  output logic [OFS_W-1:0] ea_o,
  output logic             bad_o
);
  localparam int EXT_W = OFS_W - DISP_S_W;

  base_sel_e base_sel;
  idx_sel_e  idx_sel;
  disp_sel_e disp_sel;
  logic [OFS_W-1:0] base_v, idx_v, disp_v;

  assign base_sel = base_sel_e'(base_sel_i);
  assign idx_sel  = idx_sel_e'(idx_sel_i);
  assign disp_sel = disp_sel_e'(disp_sel_i);

  always_comb begin
    unique case (base_sel)
      BASE_BX: base_v = bx_i;
      BASE_BP: base_v = bp_i;
      default: base_v = '0;
    endcase
    unique case (idx_sel)
      IDX_SI:  idx_v = si_i;
      IDX_DI:  idx_v = di_i;
      default: idx_v = '0;
    endcase
    unique case (disp_sel)
      DISP_S8:  disp_v = {{EXT_W{disp_i[DISP_S_W-1]}}, disp_i[DISP_S_W-1:0]};
      DISP_W16: disp_v = disp_i;
      default:  disp_v = '0;
    endcase
  end

  // modulo 2^OFS_W sum
  assign ea_o  = base_v + idx_v + disp_v;
  assign bad_o = (base_sel == BASE_BAD) || (idx_sel == IDX_BAD) || (disp_sel == DISP_BAD);
endmodule

// File: rtl/agu_seg.sv
module agu_seg
  import seg_agu_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             fetch_i,
  input  logic             uses_bp_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic [OFS_W-1:0] cs_i,
  input  logic [OFS_W-1:0] ds_i,
  input  logic [OFS_W-1:0] ss_i,
  input  logic [OFS_W-1:0] es_i,
  output logic [OFS_W-1:0] seg_o
);
  seg_sel_e sel;

  always_comb begin
    if (fetch_i)       sel = SEG_CS;
    else if (ovr_en_i) sel = seg_sel_e'(ovr_seg_i);
    else if (uses_bp_i) sel = SEG_SS;
    else               sel = SEG_DS;
  end

  always_comb begin
    unique case (sel)
      SEG_ES:  seg_o = es_i;
      SEG_CS:  seg_o = cs_i;
      SEG_SS:  seg_o = ss_i;
      default: seg_o = ds_i;
    endcase
  end
endmodule

// File: rtl/agu_phys.sv
module agu_phys #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0] seg_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] seg_sh, ofs_ext;

  assign seg_sh  = {seg_i, {SEG_SHIFT{1'b0}}};
  assign ofs_ext = {{SEG_SHIFT{1'b0}}, ofs_i};
  // carry out of the top bit is dropped: wraps through zero
  assign pa_o    = seg_sh + ofs_ext;
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int DISP_S_W  = 8,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fetch_i,
  input  logic [1:0]       base_sel_i,
  input  logic [1:0]       idx_sel_i,
  input  logic [1:0]       disp_sel_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic [OFS_W-1:0] cs_i,
  input  logic [OFS_W-1:0] ds_i,
  input  logic [OFS_W-1:0] ss_i,
  input  logic [OFS_W-1:0] es_i,
  input  logic [OFS_W-1:0] ip_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  output logic             valid_o,
  output logic [OFS_W-1:0] ea_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             err_o
);
  logic [OFS_W-1:0] ea_data, ea_sel, seg_val;
  logic [PA_W-1:0]  pa_calc;
  logic             bad_data, bad;

  agu_offset #(.OFS_W(OFS_W), .DISP_S_W(DISP_S_W)) u_offset (
    .base_sel_i (base_sel_i),
    .idx_sel_i  (idx_sel_i),
    .disp_sel_i (disp_sel_i),
    .disp_i     (disp_i),
    .bx_i       (bx_i),
    .bp_i       (bp_i),
    .si_i       (si_i),
    .di_i       (di_i),
    .ea_o       (ea_data),
    .bad_o      (bad_data)
  );

  agu_seg #(.OFS_W(OFS_W)) u_seg (
    .fetch_i   (fetch_i),
    .uses_bp_i (base_sel_i == BASE_BP),
    .ovr_en_i  (ovr_en_i),
    .ovr_seg_i (ovr_seg_i),
    .cs_i      (cs_i),
    .ds_i      (ds_i),
    .ss_i      (ss_i),
    .es_i      (es_i),
    .seg_o     (seg_val)
  );

  assign ea_sel = fetch_i ? ip_i : ea_data;
  assign bad    = !fetch_i && bad_data;

  agu_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_phys (
    .seg_i (seg_val),
    .ofs_i (ea_sel),
    .pa_o  (pa_calc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ea_o    <= '0;
      pa_o    <= '0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        err_o <= bad;
        ea_o  <= bad ? '0 : ea_sel;
        pa_o  <= bad ? '0 : pa_calc;
      end
    end
  end

  // segment contributes nothing below bit SEG_SHIFT
  assert_low_bits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !err_o) |-> (pa_o[SEG_SHIFT-1:0] == ea_o[SEG_SHIFT-1:0]));
  assert_err_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ea_o == '0 && pa_o == '0));
  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(pa_o) && $stable(ea_o) && $stable(err_o)));
  assert_fetch_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fetch_i) |=> (!err_o && ea_o == $past(ip_i)));
endmodule

// File: tb/tb_seg_agu.sv
module tb_seg_agu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 0, fetch_i = 0, ovr_en_i = 0;
  logic [1:0] base_sel_i = 0, idx_sel_i = 0, disp_sel_i = 0, ovr_seg_i = 0;
  logic [15:0] disp_i = 0, cs_i = 0, ds_i = 0, ss_i = 0, es_i = 0, ip_i = 0;
  logic [15:0] bx_i = 0, bp_i = 0, si_i = 0, di_i = 0;
  logic        valid_o, err_o;
  logic [15:0] ea_o;
  logic [19:0] pa_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  seg_agu dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fetch_i(fetch_i),
    .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i), .disp_sel_i(disp_sel_i),
    .disp_i(disp_i), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
    .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i), .ip_i(ip_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
    .valid_o(valid_o), .ea_o(ea_o), .pa_o(pa_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  task automatic run_one(input int fe, input int b, input int x, input int d, input int o, input bit hold);
    logic [15:0] seg, ea, dv, bv, xv;
    logic [19:0] pa;
    logic        er;
    string       tag;
    @(negedge clk);
    fetch_i = fe[0]; base_sel_i = b[1:0]; idx_sel_i = x[1:0]; disp_sel_i = d[1:0];
    ovr_en_i = (o != 4); ovr_seg_i = o[1:0]; valid_i = 1'b1;
    // expected model
    bv = (b == 1) ? bx_i : (b == 2) ? bp_i : 16'h0;
    xv = (x == 1) ? si_i : (x == 2) ? di_i : 16'h0;
    dv = (d == 1) ? {{8{disp_i[7]}}, disp_i[7:0]} : (d == 2) ? disp_i : 16'h0;
    if (fe != 0) begin
      seg = cs_i; ea = ip_i; er = 1'b0; tag = "R5";
    end else begin
      ea = bv + xv + dv;
      er = (b == 3) || (x == 3) || (d == 3);
      if (o != 4) begin
        seg = (o == 0) ? es_i : (o == 1) ? cs_i : (o == 2) ? ss_i : ds_i; tag = "R6";
      end else begin
        seg = (b == 2) ? ss_i : ds_i; tag = (b == 2) ? "R4" : (d == 1) ? "R3" : "R1";
      end
      if (er) tag = "R7";
    end
    pa = {seg, 4'h0} + {4'h0, ea};
    if (er) begin ea = '0; pa = '0; end
    @(negedge clk);
    valid_i = 1'b0;
    chk("R8 valid_o pulse", {31'b0, valid_o}, 32'd1);
    chk({tag, " err_o"}, {31'b0, err_o}, {31'b0, er});
    chk({(tag == "R7" || tag == "R5") ? tag : "R2", " ea_o"}, {16'b0, ea_o}, {16'b0, ea});
    chk({tag, " pa_o"}, {12'b0, pa_o}, {12'b0, pa});
    if (hold) begin
      fetch_i = ~fetch_i; base_sel_i = 2'd1; idx_sel_i = 2'd2; disp_sel_i = 2'd2;
      @(negedge clk);
      chk("R8 valid_o low", {31'b0, valid_o}, 32'd0);
      chk("R8 pa hold", {12'b0, pa_o}, {12'b0, pa});
      chk("R8 ea hold", {16'b0, ea_o}, {16'b0, ea});
    end
  endtask

  task automatic sweep();
    for (int fe = 0; fe < 2; fe++)
      for (int b = 0; b < 4; b++)
        for (int x = 0; x < 4; x++)
          for (int d = 0; d < 4; d++)
            for (int o = 0; o < 5; o++)
              run_one(fe, b, x, d, o, (b == x) && (d == 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid_o", {31'b0, valid_o}, 32'd0);
    chk("R9 reset pa_o", {12'b0, pa_o}, 32'd0);
    chk("R9 reset ea_o", {16'b0, ea_o}, 32'd0);
    chk("R9 reset err_o", {31'b0, err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {12'b0, pa_o}, 32'd0);

    // set 0: plain values
    cs_i = 16'h24F6; ds_i = 16'h4500; ss_i = 16'h2000; es_i = 16'h1120; ip_i = 16'h634A;
    bx_i = 16'h2100; bp_i = 16'h7814; si_i = 16'h1486; di_i = 16'h8500; disp_i = 16'h0012;
    sweep();
    // set 1: offset and physical wrap, negative byte displacement
    cs_i = 16'hFF59; ds_i = 16'hFFF0; ss_i = 16'hF000; es_i = 16'hFFFF; ip_i = 16'hFFFE;
    bx_i = 16'hFFFF; bp_i = 16'h8000; si_i = 16'h7FFF; di_i = 16'h0001; disp_i = 16'h1280;
    sweep();
    // set 2: arbitrary values
    cs_i = 16'($urandom); ds_i = 16'($urandom); ss_i = 16'($urandom); es_i = 16'($urandom);
    ip_i = 16'($urandom); bx_i = 16'($urandom); bp_i = 16'($urandom);
    si_i = 16'($urandom); di_i = 16'($urandom); disp_i = 16'($urandom);
    sweep();
    report();
  end
endmodule